// File: doc/BRIEF.md
# One-Hot Population Tally

This block counts how many of its N input bits are set and reports the count as a one-hot word of N+1 lines. Line k is high exactly when k inputs are 1. The count is not built by adding bits. A token starts on the Zero line and passes through a chain of N identical steering stages, one stage for each input bit. A stage whose bit is 0 passes every line straight through to the same position. A stage whose bit is 1 moves every line up by one position.

Stage k takes k+1 lines and produces k+2 lines. Every output line of a stage is always driven. A line that receives no routed value is driven to 0, so no position is ever left undefined.

A mode parameter selects the output form. In the registered form (the default), the tally goes through a flip-flop stage that has a synchronous reset. In the combinational form, the chain drives the outputs directly. The block has no state machine, and its only stored state is the optional output register.

Top module: `onehot_tally`

## Requirements
- R1: The token enters the chain on line 0 (Zero). When all inputs are 0, the output is 1 on bit 0 and 0 on every other bit.
- R2: A stage whose input bit is 0 passes each line to the same position. Inputs that are 0 never change the count, so all ones except one cleared bit gives bit N-1.
- R3: A stage whose input bit is 1 moves each line to the next-higher position and drives its lowest line to 0. A single set bit gives bit 1, and all bits set gives bit N.
- R4: For every input combination, the single high output bit sits at the index equal to the number of 1s on `bits_in`. With N=2 this means 00 gives bit 0, 01 or 10 gives bit 1, and 11 gives bit 2.
- R5: Exactly one bit of `tally_oh` is high in every cycle outside reset. Every other line is driven to 0.
- R6: In registered mode, `tally_oh` follows `bits_in` one clock edge later. A synchronous active-high `rst` sets `tally_oh` to the Zero value (bit 0 only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bits_in | input | N_BITS | Bits to be counted |
| tally_oh | output | N_BITS+1 | One-hot count; bit k high means k inputs are set |

## Verification
The assertions check on every cycle that the output is one-hot, that reset leaves only the Zero line set, and that an all-zero or all-one input lands on the lowest or highest line in the next cycle. Only the bench scenarios can show that each of the 256 possible input words lands on its exact popcount position. The same holds for the walking-one and walking-zero patterns that exercise the diagonal and straight paths of single stages, and for a reset applied while the input is non-zero.

// File: rtl/tally_pkg.sv
package tally_pkg;
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/tally_stage.sv
// One steering stage: widens the one-hot word by one line.
module tally_stage #(
    parameter int W_IN = 1
) (
    input  logic [W_IN-1:0] lines_in,
    input  logic            step,
    output logic [W_IN:0]   lines_out
);
    always_comb begin
        if (step) begin
            // diagonal path: every line moves up, lowest line forced low
            lines_out = {lines_in, 1'b0};
        end else begin
            // straight path: top line has no source and is forced low
            lines_out = {1'b0, lines_in};
        end
    end
endmodule

// File: rtl/tally_chain.sv
module tally_chain #(
    parameter int N_BITS = 8
) (
    input  logic [N_BITS-1:0] bits_in,
    output logic [N_BITS:0]   tally_out
);
    localparam int LINES = N_BITS + 1;

    logic [LINES-1:0] lane [0:N_BITS];

    assign lane[0] = {{(LINES-1){1'b0}}, 1'b1};

    for (genvar k = 0; k < N_BITS; k++) begin : g_stage
        logic [k+1:0] stage_out;

        tally_stage #(.W_IN(k+1)) u_stage (
            .lines_in  (lane[k][k:0]),
            .step      (bits_in[k]),
            .lines_out (stage_out)
        );

        if (k + 2 < LINES) begin : g_pad
            assign lane[k+1] = {{(LINES-k-2){1'b0}}, stage_out};
        end else begin : g_full
            assign lane[k+1] = stage_out;
        end
    end

    assign tally_out = lane[N_BITS];
endmodule

// File: rtl/onehot_tally.sv
module onehot_tally
    import tally_pkg::*;
#(
    parameter int        N_BITS = 8,
    parameter out_mode_e MODE   = OUT_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] bits_in,
    output logic [N_BITS:0]   tally_oh
);
    localparam int LINES = N_BITS + 1;
    localparam logic [LINES-1:0] ZERO_LINE = LINES'(1);

    logic [LINES-1:0] chain_q;

    tally_chain #(.N_BITS(N_BITS)) u_chain (
        .bits_in   (bits_in),
        .tally_out (chain_q)
    );

    if (MODE == OUT_REG) begin : g_reg
        logic [LINES-1:0] out_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                out_r <= ZERO_LINE;
            end else begin
                out_r <= chain_q;
            end
        end

        assign tally_oh = out_r;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign tally_oh   = chain_q;
    end
endmodule

// File: rtl/onehot_tally_chk.sv
module onehot_tally_chk
    import tally_pkg::*;
#(
    parameter int        N_BITS = 8,
    parameter out_mode_e MODE   = OUT_REG
) (
    input logic              clk,
    input logic              rst,
    input logic [N_BITS-1:0] bits_in,
    input logic [N_BITS:0]   tally_oh
);
    if (MODE == OUT_REG) begin : g_reg_chk
        // R5: exactly one line high
        assert_one_hot_R5: assert property (@(posedge clk) disable iff (rst)
            $countones(tally_oh) == 1);
        // R6: reset forces the Zero line
        assert_reset_zero_R6: assert property (@(posedge clk)
            rst |=> (tally_oh == (N_BITS+1)'(1)));
        // R1: all-zero input lands on line 0 one edge later
        assert_all_zero_R1: assert property (@(posedge clk) disable iff (rst)
            (bits_in == '0) |=> tally_oh[0]);
        // R3: all-one input lands on the top line one edge later
        assert_all_ones_R3: assert property (@(posedge clk) disable iff (rst)
            (bits_in == '1) |=> tally_oh[N_BITS]);
    end else begin : g_comb_chk
        assert_one_hot_R5: assert property (@(posedge clk) disable iff (rst)
            $countones(tally_oh) == 1);
        assert_all_zero_R1: assert property (@(posedge clk) disable iff (rst)
            (bits_in == '0) |-> tally_oh[0]);
        assert_all_ones_R3: assert property (@(posedge clk) disable iff (rst)
            (bits_in == '1) |-> tally_oh[N_BITS]);
        assert_top_low_R2: assert property (@(posedge clk) disable iff (rst)
            (bits_in[N_BITS-1] == 1'b0) |-> !tally_oh[N_BITS]);
    end
endmodule

bind onehot_tally onehot_tally_chk #(.N_BITS(N_BITS), .MODE(MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bits_in  (bits_in),
    .tally_oh (tally_oh)
);

// File: tb/tb_onehot_tally.sv
module tb_onehot_tally;
    localparam int N = 8;

    typedef struct {
        logic [N:0] exp;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] bits_in = '0;
    logic [N:0]   tally_oh;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    onehot_tally #(.N_BITS(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .bits_in  (bits_in),
        .tally_oh (tally_oh)
    );

    function automatic logic [N:0] ref_tally(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return (N+1)'(1) << c;
    endfunction

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        bits_in = v;
        it.exp = ref_tally(v);
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare one item per edge, after the register updates
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, tally_oh, it.exp);
            check("R5", (N+1)'($countones(tally_oh)), (N+1)'(1));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6", tally_oh, (N+1)'(1));          // R6 reset value
        rst = 1'b0;
        @(negedge clk);
        check("R6", tally_oh, (N+1)'(1));          // R6 zero input after reset

        drive('0, "R1");                             // R1
        drive('1, "R3");                             // R3 full count
        for (int i = 0; i < N; i++) drive(N'(1) << i, "R3");     // R3 single diagonal
        for (int i = 0; i < N; i++) drive(~(N'(1) << i), "R2");  // R2 straight path
        for (int v = 0; v < (1 << N); v++) drive(N'(v), "R4");   // R4 exhaustive
        @(negedge clk);
        @(negedge clk);

        // R6: synchronous reset while input is non-zero
        bits_in = '1;
        @(negedge clk);
        check("R6", tally_oh, ref_tally('1));
        rst = 1'b1;
        @(negedge clk);
        check("R6", tally_oh, (N+1)'(1));
        rst = 1'b0;
        @(negedge clk);
        check("R6", tally_oh, ref_tally('1));

        check("R4", (N+1)'(q.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule